// File: doc/BRIEF.md
# DMA Bus Master with Address and Word Counters

This block lets a peripheral take ownership of a shared bus and move a block of words without processor help. Software programs three registers through a simple register port: a bus address counter, a word counter and a control word. The word counter holds the negative of the number of words, in two's complement, and counts up toward zero. While the local request input is high and words remain, the block asks for the bus, waits for the grant, and then runs one address phase and one data phase per word. Each data phase is closed by the reply line from the addressed slave.

Each completed word advances the address by one or by two, as the step control selects, and advances the word counter by one. The bus is given back in four cases: the count reaches zero, the local request drops, a slave fails to reply in time, or the optional four-word burst limit is reached. After a burst-limit release the block stays off the bus for a programmable number of clocks, so other masters can win arbitration. When the block does not want the bus, it passes the daisy-chained grant on to the next device, one clock late. Completion and timeout each set a flag, and each flag can raise the interrupt output when its enable bit is set.

Top module: `dma_master`

## Requirements
- R1: The register port selects the address counter with select 0, the word counter with select 1 and the control word with select 2. A write lands at the next clock edge and read data is combinational. The control word has the completion enable at bit 0, the timeout enable at bit 1, the gap length at bits 7:4, the completion flag at bit 8 and the timeout flag at bit 9. Pulsing the clear input zeroes both counters together and leaves the control word alone.
- R2: Each completed transfer, meaning a reply while the data strobe is high, adds exactly one to the word counter.
- R3: Each completed transfer adds 2 to the address counter when step_word is high and 1 when it is low.
- R4: When req is high and the word counter is nonzero, bus_req goes high. A grant turns bus_req into sack. Each word then gets one address-strobe cycle followed by data-strobe cycles until reply. If req is low when a word completes, the bus is released.
- R5: With burst_lim high, no more than four transfers take place per bus tenure. After a release caused by the limit, bus_req rises again exactly gap+2 clocks after sack falls.
- R6: With burst_lim low and req held high, the whole block moves in a single tenure.
- R7: grant_out is grant_in delayed by one clock while the block is idle with no request to start, or while it is waiting out a gap. It is low at all other times and never high together with bus_req or sack.
- R8: A high init returns the sequencer to idle: one clock later sack and bus_req are both low.
- R9: If no reply arrives within TMO_CYC clocks of data strobe, the bus is released and the timeout flag is set. Neither counter changes, and the interrupt rises if the timeout enable is set.
- R10: When the word counter reaches zero, the bus is released and the completion flag is set. The interrupt output is the OR of each flag ANDed with its enable. Any write to the control word clears both flags.
- R11: With a word counter of zero, a high req never raises bus_req.
- R12: After reset, both counters and the control word read zero, and bus_req, sack, grant_out and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous return of the sequencer to idle |
| reg_sel | input | 2 | Register select: 0 address, 1 word count, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register |
| cnt_clr | input | 1 | Clears both counters together |
| step_word | input | 1 | 1: address steps by 2, 0: by 1 |
| burst_lim | input | 1 | Limit each tenure to four transfers |
| req | input | 1 | Local request for bus ownership |
| bus_req | output | 1 | Bus request to the arbiter |
| grant_in | input | 1 | Incoming daisy-chain grant |
| grant_out | output | 1 | Grant passed to the next device |
| sack | output | 1 | Bus ownership acknowledge |
| addr_stb | output | 1 | Address phase strobe |
| data_stb | output | 1 | Data phase strobe |
| reply | input | 1 | Slave reply ending the data phase |
| done_flag | output | 1 | Completion flag |
| tmo_flag | output | 1 | Timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
If the sequencer slips into a wrong state, it shows within one clock as a wrong combination of bus_req, sack and the two strobes. It also shows as a grant_out that leaks through while the block owns the bus. A wrong counter or step shows only when the registers are read back after a block completes, so every run ends with a readback that is compared against a count of the replies the bench model gave. Errors in the burst limit or the gap timer show as the longest tenure or the shortest release-to-request distance, which the bench bus model measures over whole runs.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_ADDR = 3'd2,
    S_DATA = 3'd3,
    S_GAP  = 3'd4
  } seq_st_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_WC   = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  localparam int unsigned GAP_W        = 4;
  localparam int unsigned CTL_IE_DONE  = 0;
  localparam int unsigned CTL_IE_TMO   = 1;
  localparam int unsigned CTL_GAP_LSB  = 4;
  localparam int unsigned CTL_DONE_BIT = 8;
  localparam int unsigned CTL_TMO_BIT  = 9;
  localparam int unsigned BURST_MAX    = 4;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [1:0]       sel,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic             clr,
  input  logic             inc,
  input  logic             step_word,
  input  logic             tmo,
  output logic [DW-1:0]    rdata,
  output logic             wc_last,
  output logic             wc_zero,
  output logic [GAP_W-1:0] gap,
  output logic             done_flag,
  output logic             tmo_flag,
  output logic             irq
);

  localparam logic [DW-1:0] STEP_ONE = DW'(1);
  localparam logic [DW-1:0] STEP_TWO = DW'(2);

  logic [DW-1:0]    addr_q, addr_d;
  logic [DW-1:0]    wc_q, wc_d;
  logic             ie_done_q, ie_done_d;
  logic             ie_tmo_q, ie_tmo_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             done_q, done_d;
  logic             tmo_q, tmo_d;
  logic [DW-1:0]    ctl_rd;

  assign wc_last = (wc_q == '1);
  assign wc_zero = (wc_q == '0);

  always_comb begin
    addr_d    = addr_q;
    wc_d      = wc_q;
    ie_done_d = ie_done_q;
    ie_tmo_d  = ie_tmo_q;
    gap_d     = gap_q;
    done_d    = done_q;
    tmo_d     = tmo_q;

    if (clr) begin
      addr_d = '0;
      wc_d   = '0;
    end else begin
      if (wr && sel == SEL_ADDR)   addr_d = wdata;
      else if (inc)                addr_d = addr_q + (step_word ? STEP_TWO : STEP_ONE);
      if (wr && sel == SEL_WC)     wc_d = wdata;
      else if (inc)                wc_d = wc_q + STEP_ONE;
    end

    if (wr && sel == SEL_CTL) begin
      ie_done_d = wdata[CTL_IE_DONE];
      ie_tmo_d  = wdata[CTL_IE_TMO];
      gap_d     = wdata[CTL_GAP_LSB +: GAP_W];
      done_d    = 1'b0;
      tmo_d     = 1'b0;
    end
    if (inc && wc_last) done_d = 1'b1;
    if (tmo)            tmo_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      wc_q      <= '0;
      ie_done_q <= 1'b0;
      ie_tmo_q  <= 1'b0;
      gap_q     <= '0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      addr_q    <= addr_d;
      wc_q      <= wc_d;
      ie_done_q <= ie_done_d;
      ie_tmo_q  <= ie_tmo_d;
      gap_q     <= gap_d;
      done_q    <= done_d;
      tmo_q     <= tmo_d;
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CTL_IE_DONE]             = ie_done_q;
    ctl_rd[CTL_IE_TMO]              = ie_tmo_q;
    ctl_rd[CTL_GAP_LSB +: GAP_W]    = gap_q;
    ctl_rd[CTL_DONE_BIT]            = done_q;
    ctl_rd[CTL_TMO_BIT]             = tmo_q;
  end

  always_comb begin
    case (sel)
      SEL_ADDR: rdata = addr_q;
      SEL_WC:   rdata = wc_q;
      SEL_CTL:  rdata = ctl_rd;
      default:  rdata = '0;
    endcase
  end

  assign gap       = gap_q;
  assign done_flag = done_q;
  assign tmo_flag  = tmo_q;
  assign irq       = (done_q & ie_done_q) | (tmo_q & ie_tmo_q);

  // R2: a lone transfer advances the word counter by exactly one
  a_r2_wc_step: assert property (@(posedge clk) disable iff (!rst_ni)
    inc && !clr && !(wr && sel == SEL_WC) |=> wc_q == $past(wc_q) + STEP_ONE);

  // R3: address step follows the step control
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_ni)
    inc && !clr && !(wr && sel == SEL_ADDR) |=>
      addr_q == $past(addr_q) + ($past(step_word) ? STEP_TWO : STEP_ONE));

  // R10: completion flag only rises with the counter at zero
  a_r10_done_at_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done_q) |-> wc_q == '0);

  // R9: a timeout leaves both counters untouched
  a_r9_tmo_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_ni)
    tmo && !inc && !clr && !wr |=> $stable(wc_q) && $stable(addr_q));

endmodule

// File: rtl/dma_rply_tmr.sv
module dma_rply_tmr #(
  parameter int unsigned TMO_CYC = 1000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic wait_i,
  output logic tmo
);

  localparam int unsigned TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (wait_i) cnt_d = cnt_q + TW'(1);
    else        cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tmo = wait_i && (cnt_q == LAST);

  // R9: the timeout fires only after the wait has lasted (TMO_CYC >= 2)
  a_r9_tmo_after_wait: assert property (@(posedge clk) disable iff (!rst_ni)
    tmo |-> $past(wait_i));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             init,
  input  logic             req,
  input  logic             burst_lim,
  input  logic             grant_i,
  input  logic             reply_i,
  input  logic             tmo_i,
  input  logic             wc_zero,
  input  logic             wc_last,
  input  logic [GAP_W-1:0] gap,
  output logic             bus_req,
  output logic             grant_o,
  output logic             sack,
  output logic             addr_stb,
  output logic             data_stb,
  output logic             inc
);

  localparam logic [2:0] NX_CAP  = 3'(BURST_MAX);
  localparam logic [2:0] NX_LAST = 3'(BURST_MAX - 1);

  seq_st_e          st_q, st_d;
  logic [2:0]       nx_q, nx_d;
  logic [GAP_W-1:0] gcnt_q, gcnt_d;
  logic             gnt_q, gnt_d;
  logic             start, pass;

  assign start = (st_q == S_IDLE) && req && !wc_zero;
  assign pass  = ((st_q == S_IDLE) && !start) || (st_q == S_GAP);

  always_comb begin
    st_d   = st_q;
    nx_d   = nx_q;
    gcnt_d = gcnt_q;
    case (st_q)
      S_IDLE: if (start) st_d = S_REQ;
      S_REQ: begin
        if (!req) st_d = S_IDLE;
        else if (grant_i) begin
          st_d = S_ADDR;
          nx_d = '0;
        end
      end
      S_ADDR: st_d = S_DATA;
      S_DATA: begin
        if (reply_i) begin
          if (nx_q != NX_CAP) nx_d = nx_q + 3'd1;
          if (wc_last || !req) st_d = S_IDLE;
          else if (burst_lim && nx_q == NX_LAST) begin
            st_d   = S_GAP;
            gcnt_d = gap;
          end else st_d = S_ADDR;
        end else if (tmo_i) st_d = S_IDLE;
      end
      S_GAP: begin
        if (gcnt_q == '0) st_d = S_IDLE;
        else              gcnt_d = gcnt_q - GAP_W'(1);
      end
      default: st_d = S_IDLE;
    endcase
    if (init) st_d = S_IDLE;
    gnt_d = grant_i && pass;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      nx_q   <= '0;
      gcnt_q <= '0;
      gnt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      nx_q   <= nx_d;
      gcnt_q <= gcnt_d;
      gnt_q  <= gnt_d;
    end
  end

  assign bus_req  = (st_q == S_REQ);
  assign sack     = (st_q == S_ADDR) || (st_q == S_DATA);
  assign addr_stb = (st_q == S_ADDR);
  assign data_stb = (st_q == S_DATA);
  assign inc      = data_stb && reply_i;
  assign grant_o  = gnt_q;

  // R8: init drops every bus-side request and ownership one clock later
  a_r8_init_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    init |=> !sack && !bus_req);

  // R7: grant passes only while the block neither asks for nor holds the bus
  a_r7_grant_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    grant_o |-> !bus_req && !sack);

  // R7: outgoing grant follows the incoming one a clock later
  a_r7_grant_delay: assert property (@(posedge clk) disable iff (!rst_ni)
    grant_o |-> $past(grant_i));

  // R5: a limited tenure never exceeds four transfers
  a_r5_burst_cap: assert property (@(posedge clk) disable iff (!rst_ni)
    sack && burst_lim |-> nx_q < NX_CAP);

  // R9: a timeout releases the bus
  a_r9_tmo_release: assert property (@(posedge clk) disable iff (!rst_ni)
    tmo_i && !reply_i |=> !sack);

  // R10: the last word releases the bus
  a_r10_last_release: assert property (@(posedge clk) disable iff (!rst_ni)
    inc && wc_last |=> !sack);

  // R4: an address phase is always followed by a data phase
  a_r4_addr_then_data: assert property (@(posedge clk) disable iff (!rst_ni)
    addr_stb && !init |=> data_stb);

endmodule

// File: rtl/dma_master.sv
module dma_master
  import dma_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned TMO_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cnt_clr,
  input  logic          step_word,
  input  logic          burst_lim,
  input  logic          req,
  output logic          bus_req,
  input  logic          grant_in,
  output logic          grant_out,
  output logic          sack,
  output logic          addr_stb,
  output logic          data_stb,
  input  logic          reply,
  output logic          done_flag,
  output logic          tmo_flag,
  output logic          irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             inc, tmo, wc_last, wc_zero;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  dma_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .sel       (reg_sel),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .clr       (cnt_clr),
    .inc       (inc),
    .step_word (step_word),
    .tmo       (tmo),
    .rdata     (reg_rdata),
    .wc_last   (wc_last),
    .wc_zero   (wc_zero),
    .gap       (gap),
    .done_flag (done_flag),
    .tmo_flag  (tmo_flag),
    .irq       (irq)
  );

  dma_seq u_seq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .init      (init),
    .req       (req),
    .burst_lim (burst_lim),
    .grant_i   (grant_in),
    .reply_i   (reply),
    .tmo_i     (tmo),
    .wc_zero   (wc_zero),
    .wc_last   (wc_last),
    .gap       (gap),
    .bus_req   (bus_req),
    .grant_o   (grant_out),
    .sack      (sack),
    .addr_stb  (addr_stb),
    .data_stb  (data_stb),
    .inc       (inc)
  );

  dma_rply_tmr #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wait_i (data_stb && !reply),
    .tmo    (tmo)
  );

endmodule

// File: tb/dma_master_tb.sv
module dma_master_tb;

  localparam int CLK_P = 10;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n, init, reg_wr, cnt_clr, step_word, burst_lim, req;
  logic [1:0] reg_sel;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic bus_req, grant_in, grant_out, sack, addr_stb, data_stb, reply;
  logic done_flag, tmo_flag, irq;

  int n_chk = 0, n_fail = 0;
  bit auto_gnt = 1, auto_rply = 1, force_gnt = 0;
  int nxfer = 0, ten_x = 0, max_ten = 0, min_gap = 9999, rel_cnt = 0, gbad = 0;
  bit measuring = 0, prev_sack = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_master #(.DW(DW), .TMO_CYC(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_clr(cnt_clr),
    .step_word(step_word), .burst_lim(burst_lim), .req(req), .bus_req(bus_req),
    .grant_in(grant_in), .grant_out(grant_out), .sack(sack), .addr_stb(addr_stb),
    .data_stb(data_stb), .reply(reply), .done_flag(done_flag), .tmo_flag(tmo_flag),
    .irq(irq));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // Bus model: arbiter, replying slave and tenure/gap/grant monitor
  initial begin
    grant_in = 1'b0;
    reply    = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_sack && !sack) begin
        if (ten_x > max_ten) max_ten = ten_x;
        ten_x = 0; measuring = 1; rel_cnt = 0;
      end else if (measuring) begin
        if (bus_req) begin
          if (rel_cnt < min_gap) min_gap = rel_cnt;
          measuring = 0;
        end else rel_cnt++;
      end
      if (grant_out && (bus_req || sack)) gbad++;
      prev_sack = sack;
      if (auto_gnt) begin
        if (sack) grant_in = 1'b0;
        else if (bus_req && !grant_in && ($urandom % 3 == 0)) grant_in = 1'b1;
      end else grant_in = force_gnt;
      if (!data_stb) reply = 1'b0;
      else if (auto_rply && !reply && ($urandom % 2 == 0)) begin
        reply = 1'b1; nxfer++; ten_x++;
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic clr_mon();
    nxfer = 0; ten_x = 0; max_ten = 0; min_gap = 9999; measuring = 0;
  endtask

  function automatic logic [DW-1:0] exp_addr(input logic [DW-1:0] b, input int n, input bit w);
    return b + DW'(n * (w ? 2 : 1));
  endfunction

  // One full block; checks R2, R3, R5, R6, R10
  task automatic run_block(input logic [DW-1:0] base, input int n, input bit w,
                           input bit lim, input int gap, input bit ie);
    logic [DW-1:0] v;
    int guard;
    wr_reg(2'd0, base);
    wr_reg(2'd1, DW'(-n));
    wr_reg(2'd2, DW'((gap << 4) | (ie ? 1 : 0)));
    step_word = w; burst_lim = lim;
    clr_mon();
    req = 1'b1;
    guard = 0;
    while (!(nxfer == n && !sack && !bus_req) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    cyc(3);
    req = 1'b0;
    cyc(2);
    rd_reg(2'd0, v);
    chk(v == exp_addr(base, n, w), "R3 address after block", v, exp_addr(base, n, w));
    rd_reg(2'd1, v);
    chk(v == '0, "R2 word count reaches zero", v, 0);
    chk(nxfer == n, "R2 transfers made", nxfer, n);
    rd_reg(2'd2, v);
    chk(v[8] == 1'b1, "R10 done flag", v[8], 1);
    chk(irq == ie, "R10 irq follows enable", irq, ie);
    if (lim) begin
      chk(max_ten == (n > 4 ? 4 : n), "R5 longest tenure", max_ten, (n > 4 ? 4 : n));
      // release at edge E, request at E+gap+2: gap+1 counted negedges
      if (n > 4) chk(min_gap == gap + 1, "R5 release-to-request gap", min_gap, gap + 1);
    end else begin
      chk(max_ten == n, "R6 single tenure", max_ten, n);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung");
    report();
  end

  initial begin
    logic [DW-1:0] v;
    int guard;
    void'($urandom(32'd1234));
    rst_n = 1'b0; init = 1'b0; reg_wr = 1'b0; cnt_clr = 1'b0; step_word = 1'b1;
    burst_lim = 1'b0; req = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);

    // R12 reset state
    rd_reg(2'd0, v); chk(v == 0, "R12 address reset", v, 0);
    rd_reg(2'd1, v); chk(v == 0, "R12 word count reset", v, 0);
    rd_reg(2'd2, v); chk(v == 0, "R12 control reset", v, 0);
    chk(!bus_req && !sack && !grant_out && !irq, "R12 outputs low",
        {bus_req, sack, grant_out, irq}, 0);

    // R1 register access and joint clear
    wr_reg(2'd0, 16'h1234); wr_reg(2'd1, 16'hFFF0);
    rd_reg(2'd0, v); chk(v == 16'h1234, "R1 address write", v, 16'h1234);
    rd_reg(2'd1, v); chk(v == 16'hFFF0, "R1 count write", v, 16'hFFF0);
    wr_reg(2'd2, 16'h0053);
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    rd_reg(2'd0, v); chk(v == 0, "R1 clear address", v, 0);
    rd_reg(2'd1, v); chk(v == 0, "R1 clear count", v, 0);
    rd_reg(2'd2, v); chk(v == 16'h0053, "R1 clear spares control", v, 16'h0053);

    // R11 zero count never requests
    req = 1'b1;
    guard = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (bus_req) guard++; end
    chk(guard == 0, "R11 no request at zero count", guard, 0);
    req = 1'b0;

    // Directed blocks
    run_block(16'h0100, 5, 1'b1, 1'b0, 0, 1'b1);
    run_block(16'h0200, 3, 1'b0, 1'b0, 0, 1'b0);
    run_block(16'hFFFC, 10, 1'b1, 1'b1, 5, 1'b1);
    wr_reg(2'd2, 16'h0000);
    chk(irq == 1'b0, "R10 control write clears flags", irq, 0);

    // R4 dropping req ends mastership mid-block
    wr_reg(2'd0, 16'h0400); wr_reg(2'd1, DW'(-20)); step_word = 1'b1; burst_lim = 1'b0;
    clr_mon(); req = 1'b1;
    guard = 0;
    while (nxfer < 3 && guard < 5000) begin @(negedge clk); guard++; end
    req = 1'b0;
    guard = 0;
    while (sack && guard < 500) begin @(negedge clk); guard++; end
    chk(!sack && !bus_req, "R4 release on request drop", {sack, bus_req}, 0);
    rd_reg(2'd1, v);
    chk(v == DW'(nxfer - 20), "R4 count after early release", v, DW'(nxfer - 20));
    rd_reg(2'd0, v);
    chk(v == exp_addr(16'h0400, nxfer, 1'b1), "R3 address after early release", v,
        exp_addr(16'h0400, nxfer, 1'b1));
    chk(done_flag == 1'b0, "R10 no done before zero", done_flag, 0);

    // R7 grant pass-through
    auto_gnt = 0; force_gnt = 1; cyc(3);
    chk(grant_out == 1'b1, "R7 grant passed when idle", grant_out, 1);
    force_gnt = 0; cyc(3);
    chk(grant_out == 1'b0, "R7 grant follows low", grant_out, 0);
    wr_reg(2'd1, DW'(-3)); req = 1'b1;
    guard = 0;
    while (!bus_req && guard < 50) begin @(negedge clk); guard++; end
    force_gnt = 1;
    guard = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (grant_out) guard++; end
    chk(guard == 0, "R7 grant blocked while requesting", guard, 0);
    req = 1'b0;
    guard = 0;
    while (sack && guard < 500) begin @(negedge clk); guard++; end
    cyc(3);
    chk(grant_out == 1'b1, "R7 grant passed after release", grant_out, 1);
    force_gnt = 0; auto_gnt = 1; cyc(3);

    // R9 reply timeout
    auto_rply = 0;
    wr_reg(2'd0, 16'h0100); wr_reg(2'd1, DW'(-2)); wr_reg(2'd2, 16'h0002);
    req = 1'b1;
    guard = 0;
    while (!sack && guard < 200) begin @(negedge clk); guard++; end
    guard = 0;
    while (sack && guard < 500) begin @(negedge clk); guard++; end
    req = 1'b0;
    chk(guard > 60 && guard < 500, "R9 timeout releases bus", guard, 64);
    cyc(2);
    chk(tmo_flag == 1'b1 && irq == 1'b1, "R9 timeout flag and irq", {tmo_flag, irq}, 3);
    rd_reg(2'd1, v); chk(v == DW'(-2), "R9 count unchanged", v, DW'(-2));
    rd_reg(2'd0, v); chk(v == 16'h0100, "R9 address unchanged", v, 16'h0100);

    // R8 init during an open data phase
    req = 1'b1;
    guard = 0;
    while (!data_stb && guard < 200) begin @(negedge clk); guard++; end
    init = 1'b1; req = 1'b0;
    @(negedge clk);
    chk(!sack && !bus_req, "R8 init drops ownership", {sack, bus_req}, 0);
    init = 1'b0; auto_rply = 1;
    cyc(3);

    // Random blocks
    for (int k = 0; k < 6; k++) begin
      run_block(DW'($urandom), 1 + int'($urandom % 12), 1'($urandom), 1'($urandom),
                int'($urandom % 8), 1'($urandom));
    end

    chk(gbad == 0, "R7 grant never overlaps ownership", gbad, 0);
    report();
  end

endmodule